// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a register-mapped asynchronous serial port. Software writes bytes into a transmit queue and reads received bytes out of a receive queue through a word-wide register port. Each queue holds eight bytes. The serial line carries frames with 8 data bits and no parity bit. Each frame ends with one or two stop bits. The bit rate comes from a 16-bit divisor: every bit lasts divisor+1 clock cycles.

Interrupts are level signals derived from queue occupancy rather than from individual characters. The transmit source is pending while the transmit queue holds fewer bytes than a programmed threshold. The receive source is pending while the receive queue holds more bytes than its own threshold. Both pending flags are masked by an enable register and ORed into one interrupt line. Software learns about a full transmit queue or an empty receive queue from bit 31 of the data registers themselves.

The register port is a plain valid/write/address/data interface. Read data is combinational for the addressed word. The register word index is taken from address bits 4:2, and bits 1:0 must be zero.

Top module: `wm_uart`

## Requirements
- R1: Out of reset:
  - txd is high and irq is low.
  - The transmit-control, receive-control, enable and pending words read zero, and the divisor reads the DIV_RESET value (default 0).
  - The transmit data word reads 0x0000_0000 and the receive data word reads 0x8000_0000.
- R2: Transmit data word (byte address 0x00):
  - A write queues bits 7:0.
  - A read returns bit 31 set exactly when the transmit queue holds FIFO_DEPTH bytes.
  - A write while the queue is full is dropped.
- R3: Frame format and divisor:
  - A transmitted frame is a low start bit, then the 8 data bits least significant first, then a high stop bit.
  - Transmit-control bit 1 = 1 adds a second high stop bit.
  - Each bit lasts divisor+1 cycles, with the divisor written and read back in bits 15:0 of byte address 0x18.
  - Back-to-back frames start exactly 10 (or 11) bit periods apart.
- R4: While transmit-control (0x08) bit 0 is 0, txd stays high and queued bytes are kept. Once the bit is set, they are sent in order.
- R5: Receive data word (0x04):
  - A read returns the oldest received byte in bits 7:0 and an empty flag in bit 31 (bits 7:0 are 0 when empty).
  - A read while the queue is not empty removes one byte.
- R6: While receive-control (0x0C) bit 0 is 0, frames on rxd are ignored and the receive queue stays empty.
- R7: When the receive queue already holds FIFO_DEPTH bytes, further frames are discarded, and the stored bytes are read back in arrival order.
- R8: Pending-word (0x14) bit 0 is high exactly while transmit-queue occupancy is below transmit-control bits 18:16. It rises as soon as the last byte leaves the queue, while that byte's frame is still on the line.
- R9: Pending-word bit 1 is high exactly while receive-queue occupancy exceeds receive-control bits 18:16.
- R10: irq is the OR of the pending bits whose enable bits are set in the enable word (0x10: bit 0 transmit, bit 1 receive).
- R11: The pending word is read-only. Writing it changes neither its value, nor the enable word, nor irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (5) | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The assertions watch several properties on every cycle:
- Neither queue's occupancy exceeds its depth.
- The full flag seen on a transmit-data read agrees with the queue level.
- A receive read with no simultaneous arrival drops the level by exactly one.
- A disabled, idle transmitter stays idle with the line high.
- No interrupt appears with both enables clear.

Frame timing, bit order and stop-bit count on the line need the bench's scenarios, and so do the threshold comparisons for random thresholds and fill levels, discarding on overflow, and the ordering of bytes through both queues. The pending flag rising while the last frame is still shifting out can also only be shown by a bench scenario.

// File: rtl/wm_uart_pkg.sv
package wm_uart_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int WM_W    = 3;
    localparam int WM_LSB  = 16;
    localparam int FLAG_BIT = 31;

    typedef enum logic [2:0] {
        IDX_TXDATA = 3'd0,
        IDX_RXDATA = 3'd1,
        IDX_TXCTRL = 3'd2,
        IDX_RXCTRL = 3'd3,
        IDX_IE     = 3'd4,
        IDX_IP     = 3'd5,
        IDX_DIV    = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic [WM_W-1:0] wm;
        logic            two_stop;
        logic            en;
    } tx_cfg_t;

    typedef struct packed {
        logic [WM_W-1:0] wm;
        logic            en;
    } rx_cfg_t;

    typedef struct packed {
        logic rx;
        logic tx;
    } irq_vec_t;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_state_e;

    function automatic logic [WORD_W-1:0] tx_cfg_to_word(input tx_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[0] = c.en;
        w[1] = c.two_stop;
        w[WM_LSB +: WM_W] = c.wm;
        return w;
    endfunction

    function automatic tx_cfg_t word_to_tx_cfg(input logic [WORD_W-1:0] w);
        tx_cfg_t c;
        c.en       = w[0];
        c.two_stop = w[1];
        c.wm       = w[WM_LSB +: WM_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] rx_cfg_to_word(input rx_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[0] = c.en;
        w[WM_LSB +: WM_W] = c.wm;
        return w;
    endfunction

    function automatic rx_cfg_t word_to_rx_cfg(input logic [WORD_W-1:0] w);
        rx_cfg_t c;
        c.en = w[0];
        c.wm = w[WM_LSB +: WM_W];
        return c;
    endfunction

endpackage

// File: rtl/wm_fifo.sv
module wm_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/wm_uart_tx.sv
module wm_uart_tx
    import wm_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              two_stop,
    input  logic [DIV_W-1:0]  div,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_head,
    output logic              fifo_pop,
    output logic              txd,
    output logic              busy
);

    localparam int IDX_W = $clog2(BYTE_W);

    line_state_e       state;
    logic [DIV_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic              stop_idx;
    logic              bit_done, frame_end, launch;

    assign bit_done  = (cnt >= div);
    assign frame_end = (state == LN_STOP) && bit_done && (stop_idx || !two_stop);
    assign launch    = ((state == LN_IDLE) || frame_end) && en && !fifo_empty;
    assign fifo_pop  = launch;
    assign busy      = (state != LN_IDLE);

    always_comb begin
        case (state)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LN_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
        end else begin
            if (state != LN_IDLE) begin
                cnt <= bit_done ? '0 : cnt + DIV_W'(1);
            end
            if (launch) begin
                state <= LN_START;
                shreg <= fifo_head;
                cnt   <= '0;
            end else begin
                case (state)
                    LN_START: begin
                        if (bit_done) begin
                            state   <= LN_DATA;
                            bit_idx <= '0;
                        end
                    end
                    LN_DATA: begin
                        if (bit_done) begin
                            shreg <= shreg >> 1;
                            if (bit_idx == IDX_W'(BYTE_W - 1)) begin
                                state    <= LN_STOP;
                                stop_idx <= 1'b0;
                            end else begin
                                bit_idx <= bit_idx + IDX_W'(1);
                            end
                        end
                    end
                    LN_STOP: begin
                        if (frame_end) begin
                            state <= LN_IDLE;
                        end else if (bit_done) begin
                            stop_idx <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/wm_uart_rx.sv
module wm_uart_rx
    import wm_uart_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic              rxd,
    output logic              push,
    output logic [BYTE_W-1:0] push_data
);

    localparam int IDX_W = $clog2(BYTE_W);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    line_state_e            state;
    logic [DIV_W-1:0]       cnt;
    logic [BYTE_W-1:0]      shreg;
    logic [IDX_W-1:0]       bit_idx;
    logic                   half_done, bit_done;

    assign rx_s      = sync_q[SYNC_STAGES-1];
    assign half_done = (cnt >= (div >> 1));
    assign bit_done  = (cnt >= div);
    assign push_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LN_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            push    <= 1'b0;
        end else begin
            push <= 1'b0;
            case (state)
                LN_IDLE: begin
                    cnt <= '0;
                    if (en && !rx_s) begin
                        state <= LN_START;
                    end
                end
                LN_START: begin
                    if (half_done) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= rx_s ? LN_IDLE : LN_DATA;
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                LN_DATA: begin
                    if (bit_done) begin
                        cnt   <= '0;
                        shreg <= {rx_s, shreg[BYTE_W-1:1]};
                        if (bit_idx == IDX_W'(BYTE_W - 1)) begin
                            state <= LN_STOP;
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                LN_STOP: begin
                    if (bit_done) begin
                        cnt   <= '0;
                        state <= LN_IDLE;
                        push  <= rx_s;
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                default: state <= LN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wm_uart.sv
module wm_uart
    import wm_uart_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 16,
    parameter int DIV_RESET  = 0,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              txd,
    input  logic              rxd
);

    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
    localparam int IDX_LSB = 2;

    tx_cfg_t           tx_cfg;
    rx_cfg_t           rx_cfg;
    irq_vec_t          ie_q, ip;
    logic [DIV_W-1:0]  div_q;

    reg_idx_e          sel;
    logic              hit, wr, rd;
    logic              tx_push, tx_pop, tx_full, tx_empty, tx_busy;
    logic [BYTE_W-1:0] tx_head;
    logic [CNT_W-1:0]  tx_count;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [BYTE_W-1:0] rx_head, rx_byte;
    logic [CNT_W-1:0]  rx_count;

    assign sel = reg_idx_e'(reg_addr[IDX_LSB +: 3]);
    assign hit = reg_valid && (reg_addr[1:0] == 2'b00) && ((reg_addr >> 5) == '0);
    assign wr  = hit && reg_write;
    assign rd  = hit && !reg_write;

    assign tx_push = wr && (sel == IDX_TXDATA);
    assign rx_pop  = rd && (sel == IDX_RXDATA);

    assign ip.tx = (tx_count < CNT_W'(tx_cfg.wm));
    assign ip.rx = (rx_count > CNT_W'(rx_cfg.wm));
    assign irq   = |(ie_q & ip);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_cfg <= '0;
            rx_cfg <= '0;
            ie_q   <= '0;
            div_q  <= DIV_W'(DIV_RESET);
        end else if (wr) begin
            case (sel)
                IDX_TXCTRL: tx_cfg <= word_to_tx_cfg(reg_wdata);
                IDX_RXCTRL: rx_cfg <= word_to_rx_cfg(reg_wdata);
                IDX_IE:     ie_q   <= irq_vec_t'(reg_wdata[1:0]);
                IDX_DIV:    div_q  <= reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            IDX_TXDATA: reg_rdata[FLAG_BIT] = tx_full;
            IDX_RXDATA: begin
                reg_rdata[FLAG_BIT]   = rx_empty;
                reg_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
            end
            IDX_TXCTRL: reg_rdata = tx_cfg_to_word(tx_cfg);
            IDX_RXCTRL: reg_rdata = rx_cfg_to_word(rx_cfg);
            IDX_IE:     reg_rdata[1:0] = ie_q;
            IDX_IP:     reg_rdata[1:0] = ip;
            IDX_DIV:    reg_rdata[DIV_W-1:0] = div_q;
            default: ;
        endcase
    end

    wm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push),
        .push_data (reg_wdata[BYTE_W-1:0]),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    wm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    wm_uart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .en         (tx_cfg.en),
        .two_stop   (tx_cfg.two_stop),
        .div        (div_q),
        .fifo_empty (tx_empty),
        .fifo_head  (tx_head),
        .fifo_pop   (tx_pop),
        .txd        (txd),
        .busy       (tx_busy)
    );

    wm_uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_cfg.en),
        .div       (div_q),
        .rxd       (rxd),
        .push      (rx_push),
        .push_data (rx_byte)
    );

endmodule

// File: rtl/wm_uart_chk.sv
module wm_uart_chk #(
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 5,
    parameter int CNT_W      = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              irq,
    input logic              txd,
    input logic [1:0]        ie_bits,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_push,
    input logic              tx_busy,
    input logic              tx_en
);

    logic rd_tx, rd_rx;
    assign rd_tx = reg_valid && !reg_write && (reg_addr == ADDR_W'(5'h00));
    assign rd_rx = reg_valid && !reg_write && (reg_addr == ADDR_W'(5'h04));

    // R2
    tx_level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CNT_W'(FIFO_DEPTH));

    // R7
    rx_level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(FIFO_DEPTH));

    // R2
    tx_full_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rd_tx |-> (reg_rdata[31] == (tx_count == CNT_W'(FIFO_DEPTH))));

    // R5
    rx_pop_one_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && (rx_count != '0) && !rx_push) |=> (rx_count == $past(rx_count) - CNT_W'(1)));

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !tx_busy) |=> (!tx_busy && txd));

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (ie_bits == 2'b00) |-> !irq);

endmodule

bind wm_uart wm_uart_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W)
) u_wm_uart_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .txd       (txd),
    .ie_bits   (ie_q),
    .tx_count  (tx_count),
    .rx_count  (rx_count),
    .rx_push   (rx_push),
    .tx_busy   (tx_busy),
    .tx_en     (tx_cfg.en)
);

// File: tb/test_wm_uart.sv
`timescale 1ns/1ps
module test_wm_uart;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        txd;
    logic        rxd = 1'b1;

    localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_TXC = 3'd2, A_RXC = 3'd3,
                           A_IE = 3'd4, A_IP = 3'd5, A_DIV = 3'd6;

    always #2.5 clk = ~clk;

    wm_uart i_wm_uart (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .txd(txd), .rxd(rxd)
    );

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    int     bit_p = 4;
    int     mon_stops = 1;
    int     mon_n = 0;
    logic [7:0] mon_bytes [64];
    longint     mon_start [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = {idx, 2'b00}; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = {idx, 2'b00};
        #1 v = reg_rdata;
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_p) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = b[k];
            repeat (bit_p) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (bit_p + 2) @(negedge clk);
    endtask

    // serial line monitor on txd: samples mid-bit, records bytes and start cycles
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                longint     t0;
                logic [7:0] b;
                logic       bad;
                t0  = cyc;
                bad = 1'b0;
                repeat (bit_p / 2) @(negedge clk);
                if (txd !== 1'b0) bad = 1'b1;
                for (int k = 0; k < 8; k++) begin
                    repeat (bit_p) @(negedge clk);
                    b[k] = txd;
                end
                for (int s = 0; s < mon_stops; s++) begin
                    repeat (bit_p) @(negedge clk);
                    if (txd !== 1'b1) bad = 1'b1;
                end
                chk("R3", "start/stop bit levels", {31'd0, bad}, 32'd0);
                if (mon_n < 64) begin
                    mon_bytes[mon_n] = b;
                    mon_start[mon_n] = t0;
                end
                mon_n++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v0;
        logic [7:0]  data [9];
        int          polls;
        void'($urandom(32'h5eed_0042));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "txd idle", {31'd0, txd}, 32'd1);
        chk("R1", "irq low", {31'd0, irq}, 32'd0);
        rd(A_TXD, v); chk("R1", "txdata word", v, 32'h0);
        rd(A_RXD, v); chk("R1", "rxdata word", v, 32'h8000_0000);
        rd(A_TXC, v); chk("R1", "txctrl", v, 32'h0);
        rd(A_RXC, v); chk("R1", "rxctrl", v, 32'h0);
        rd(A_IE, v);  chk("R1", "ie", v, 32'h0);
        rd(A_IP, v);  chk("R1", "ip", v, 32'h0);
        rd(A_DIV, v); chk("R1", "div", v, 32'h0);

        // R3 divisor readback, 4 cycles per bit
        wr(A_DIV, 32'd3);
        bit_p = 4;
        rd(A_DIV, v); chk("R3", "divisor readback", v, 32'd3);

        // R8 / R10 tx watermark with empty queue
        wr(A_TXC, 32'h0001_0000);
        rd(A_IP, v); chk("R8", "txwm with empty queue, count 1", v[0], 1'b1);
        wr(A_IE, 32'h1);
        chk("R10", "irq with tx enabled", {31'd0, irq}, 32'd1);
        wr(A_IE, 32'h0);
        chk("R10", "irq masked", {31'd0, irq}, 32'd0);

        // R4 / R2 queue while disabled, 9th write dropped
        for (int i = 0; i < 9; i++) begin
            data[i] = 8'($urandom);
            wr(A_TXD, {24'd0, data[i]});
        end
        rd(A_TXD, v); chk("R2", "full flag", v, 32'h8000_0000);
        rd(A_IP, v);  chk("R8", "txwm with full queue", v[0], 1'b0);
        repeat (100) @(negedge clk);
        chk("R4", "no frames while disabled", mon_n, 0);
        chk("R4", "txd high while disabled", {31'd0, txd}, 32'd1);
        wr(A_TXC, 32'h0001_0001);
        polls = 0;
        do begin
            rd(A_IP, v);
            polls++;
        end while (!v[0] && polls < 2000);
        chk("R8", "txwm rises while last frame in flight", mon_n, 7);
        repeat (150) @(negedge clk);
        chk("R2", "frames after overflow", mon_n, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R2", "tx byte order", {24'd0, mon_bytes[i]}, {24'd0, data[i]});
        end
        for (int i = 0; i < 7; i++) begin
            chk("R3", "one-stop frame spacing", 32'(mon_start[i+1] - mon_start[i]), 32'd40);
        end

        // R3 two stop bits
        mon_n = 0; mon_stops = 2;
        wr(A_TXC, 32'h0001_0003);
        for (int i = 0; i < 3; i++) begin
            data[i] = 8'($urandom);
            wr(A_TXD, {24'd0, data[i]});
        end
        repeat (3 * 44 + 40) @(negedge clk);
        chk("R3", "two-stop frame count", mon_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R3", "two-stop byte", {24'd0, mon_bytes[i]}, {24'd0, data[i]});
        end
        for (int i = 0; i < 2; i++) begin
            chk("R3", "two-stop frame spacing", 32'(mon_start[i+1] - mon_start[i]), 32'd44);
        end
        mon_stops = 1;

        // R8 random thresholds and fill levels
        for (int it = 0; it < 6; it++) begin
            int wm, n;
            wm = int'($urandom % 8);
            n  = int'($urandom % 9);
            wr(A_TXC, 32'(wm) << 16);
            mon_n = 0;
            for (int i = 0; i < n; i++) begin
                data[i] = 8'($urandom);
                wr(A_TXD, {24'd0, data[i]});
            end
            rd(A_IP, v);
            chk("R8", "txwm vs random level", v[0], (n < wm));
            wr(A_TXC, (32'(wm) << 16) | 32'h1);
            repeat (n * 40 + 60) @(negedge clk);
            chk("R4", "queued bytes sent after enable", mon_n, n);
            for (int i = 0; i < n; i++) begin
                chk("R2", "random tx byte", {24'd0, mon_bytes[i]}, {24'd0, data[i]});
            end
        end

        // R5 / R9 receive
        wr(A_RXC, 32'h1);
        data[0] = 8'($urandom);
        send_rx(data[0]);
        rd(A_IP, v);  chk("R9", "rxwm with one byte, count 0", v[1], 1'b1);
        rd(A_RXD, v); chk("R5", "received byte", v, {24'd0, data[0]});
        rd(A_RXD, v); chk("R5", "empty after pop", v, 32'h8000_0000);
        rd(A_IP, v);  chk("R9", "rxwm after drain", v[1], 1'b0);

        // R6 receiver disabled
        wr(A_RXC, 32'h0);
        send_rx(8'($urandom));
        rd(A_RXD, v); chk("R6", "frame ignored while disabled", v, 32'h8000_0000);

        // R7 / R9 overflow with threshold 7
        wr(A_RXC, 32'h0007_0001);
        for (int i = 0; i < 9; i++) begin
            data[i] = 8'($urandom);
            send_rx(data[i]);
            if (i == 6) begin
                rd(A_IP, v); chk("R9", "rxwm at 7 of threshold 7", v[1], 1'b0);
            end
            if (i == 7) begin
                rd(A_IP, v); chk("R9", "rxwm at 8 of threshold 7", v[1], 1'b1);
            end
        end
        for (int i = 0; i < 8; i++) begin
            rd(A_RXD, v); chk("R7", "rx byte order after overflow", v, {24'd0, data[i]});
        end
        rd(A_RXD, v); chk("R7", "ninth byte discarded", v, 32'h8000_0000);

        // R9 random thresholds and fill levels
        for (int it = 0; it < 5; it++) begin
            int wm, n;
            wm = int'($urandom % 8);
            n  = int'($urandom % 9);
            wr(A_RXC, (32'(wm) << 16) | 32'h1);
            for (int i = 0; i < n; i++) begin
                data[i] = 8'($urandom);
                send_rx(data[i]);
            end
            rd(A_IP, v);
            chk("R9", "rxwm vs random level", v[1], (n > wm));
            for (int i = 0; i < n; i++) begin
                rd(A_RXD, v); chk("R5", "random rx byte", v, {24'd0, data[i]});
            end
            rd(A_RXD, v); chk("R5", "drained", v, 32'h8000_0000);
        end

        // R10 interrupt masking with both sources
        wr(A_TXC, 32'h0001_0001);
        wr(A_RXC, 32'h1);
        wr(A_IE, 32'h2);
        chk("R10", "tx pending but masked", {31'd0, irq}, 32'd0);
        send_rx(8'($urandom));
        chk("R10", "rx pending and enabled", {31'd0, irq}, 32'd1);
        rd(A_RXD, v);
        chk("R10", "rx cleared by pop", {31'd0, irq}, 32'd0);
        wr(A_IE, 32'h3);
        chk("R10", "tx pending and enabled", {31'd0, irq}, 32'd1);
        wr(A_IE, 32'h0);

        // R11 pending word read-only
        rd(A_IP, v0);
        wr(A_IP, 32'hFFFF_FFFF);
        rd(A_IP, v); chk("R11", "ip unchanged by write", v, v0);
        rd(A_IE, v); chk("R11", "ie unchanged by ip write", v, 32'h0);
        chk("R11", "irq unchanged by ip write", {31'd0, irq}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule